// File: doc/BRIEF.md
# External Interrupt Edge/Level Controller

This block watches 24 external interrupt lines and turns activity on them into interrupt requests for a CPU-side interrupt controller. Each line is first brought into the clock domain by a two-flop synchroniser. It is then judged against a 3-bit trigger mode of its own. The mode selects low level, high level, falling edge, rising edge or both edges. Edges are found by comparing the synchronised level with the level held one cycle earlier.

Lines 0 to 3 drive four separate request outputs and cannot be masked. Lines 4 to 23 are grouped. A triggered grouped line whose mask bit is clear sets its pending bit and raises the shared request for its group. One group covers lines 4 to 7 and the other covers lines 8 to 23. Software reaches the block through a small register port with one address. Writes are strobed and reads are combinational. Through this port it programs three trigger words, the mask and three filter words, which are stored but not used. It also reads the pending word and clears bits by writing ones to them.

Top module: `eint_ctrl`

## Requirements
- R1: After reset the mask reads 0x00fffff0, and the pending word, the three trigger words, the three filter words and all request outputs read 0.
- R2: The mask is at address 3. A write stores the written value ANDed with 0x00fffff0, so bits 0 to 3 and bits 24 to 31 always read 0.
- R3: The pending word is at address 4. A write clears each pending bit where the written value has a 1 and leaves the other bits unchanged. Writing 0 changes nothing.
- R4: Line n takes its mode from bits 4*(n%8)+2 down to 4*(n%8) of the trigger word at address n/8. Mode 000 triggers while the line is low and mode 001 triggers while it is high. A level trigger repeats on every cycle for as long as the level lasts.
- R5: Modes 010 and 011 trigger for exactly one cycle when the line changes from 1 to 0.
- R6: Modes 100 and 101 trigger for exactly one cycle when the line changes from 0 to 1, and give nothing when it changes from 1 to 0.
- R7: Modes 110 and 111 trigger for one cycle on each change of the line, in either direction.
- R8: A trigger on line k, for k from 0 to 3, drives `irq_direct[k]` whatever the mask holds. Such a trigger never sets a pending bit.
- R9: An unmasked trigger on any of lines 4 to 7 drives `irq_grp_lo`, and one on any of lines 8 to 23 drives `irq_grp_hi`. A grouped line with its mask bit set raises no request and sets no pending bit.
- R10: An unmasked trigger on a grouped line sets its pending bit. The bit stays set until software clears it, and a new trigger wins over a clear made in the same cycle.
- R11: A change on an input pin shows at the request outputs and in the pending word after the third rising clock edge that follows it.
- R12: The three filter words are at addresses 5 to 7. Each stores and returns all 32 bits and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 24 | Raw external interrupt lines |
| addr | input | 4 | Register address, used for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the addressed register |
| irq_direct | output | 4 | Individual requests for lines 0 to 3 |
| irq_grp_lo | output | 1 | Shared request for lines 4 to 7 |
| irq_grp_hi | output | 1 | Shared request for lines 8 to 23 |

## Verification
The lines' edge history is internal state. If it is wrong, it appears at the ports as a missing, doubled or wrong-direction request pulse. It also appears as a pulse that arrives earlier or later than the third edge after the pin change. The bench therefore records both the number of high cycles and the first high cycle inside a six-cycle window. A wrong mask or pending state appears within that same window as a grouped request that should not be there, or as a pending word that differs from the expected value when it is read back. Extra set or cleared bits in that word are caught on the read that comes straight after a clear.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;

    localparam int NLINES        = 24;
    localparam int DW            = 32;
    localparam int AW            = 4;
    localparam int NCFG          = 3;
    localparam int NFILT         = 3;
    localparam int LINES_PER_WD  = 8;
    localparam int FIELD_STRIDE  = DW / LINES_PER_WD;
    localparam int NDIRECT       = 4;
    localparam int GRP_LO_MSB    = 7;
    localparam int GRP_HI_LSB    = GRP_LO_MSB + 1;
    localparam logic [DW-1:0] GROUPED_MASK = 32'h00ff_fff0;

    typedef enum logic [AW-1:0] {
        A_CFG0  = 4'd0,
        A_CFG1  = 4'd1,
        A_CFG2  = 4'd2,
        A_MASK  = 4'd3,
        A_PEND  = 4'd4,
        A_FILT0 = 4'd5,
        A_FILT1 = 4'd6,
        A_FILT2 = 4'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_RISE  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_kind_e;

    typedef struct packed {
        trig_kind_e kind;
        logic       polarity;
    } trig_mode_t;

    function automatic logic trig_eval(trig_mode_t m, logic lvl, logic prev);
        case (m.kind)
            TRIG_LEVEL: return m.polarity ? lvl : !lvl;
            TRIG_FALL:  return prev && !lvl;
            TRIG_RISE:  return !prev && lvl;
            default:    return prev ^ lvl;
        endcase
    endfunction

endpackage

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
module eint_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '0;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
`timescale 1ns/1ps
module eint_detect
    import eint_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NLINES-1:0]    lvl,
    input  logic [NCFG*DW-1:0]   cfg_flat,
    output logic [NLINES-1:0]    hit
);
    logic [NLINES-1:0] prev;
    logic              unused_cfg_bits;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign unused_cfg_bits = ^cfg_flat;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        localparam int BASE = (i / LINES_PER_WD) * DW + (i % LINES_PER_WD) * FIELD_STRIDE;
        trig_mode_t m;
        assign m      = trig_mode_t'(cfg_flat[BASE +: 3]);
        assign hit[i] = trig_eval(m, lvl[i], prev[i]);

        // R5 / R6: a one-direction edge mode gives a single-cycle trigger
        p_edge_once_r5: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && (m.kind == TRIG_FALL || m.kind == TRIG_RISE))
            |=> (!$stable(m) || !hit[i]));
    end
endmodule

// File: rtl/eint_regs.sv
`timescale 1ns/1ps
module eint_regs
    import eint_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW-1:0]      set_i,
    output logic [DW-1:0]      rd_data,
    output logic [NCFG*DW-1:0] cfg_flat,
    output logic [DW-1:0]      mask_o,
    output logic [DW-1:0]      pend_o
);
    logic [DW-1:0] cfg  [NCFG];
    logic [DW-1:0] filt [NFILT];
    logic [DW-1:0] mask_q, pend_q;
    logic          pend_wr;

    assign pend_wr = wr_en && (addr == A_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NCFG; k++)  cfg[k]  <= '0;
            for (int k = 0; k < NFILT; k++) filt[k] <= '0;
            mask_q <= GROUPED_MASK;
        end else if (wr_en) begin
            for (int k = 0; k < NCFG; k++)
                if (addr == AW'(int'(A_CFG0) + k)) cfg[k] <= wr_data;
            for (int k = 0; k < NFILT; k++)
                if (addr == AW'(int'(A_FILT0) + k)) filt[k] <= wr_data;
            if (addr == A_MASK) mask_q <= wr_data & GROUPED_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_wr ? (pend_q & ~wr_data) : pend_q) | (set_i & GROUPED_MASK);
    end

    always_comb begin
        case (addr)
            A_CFG0:  rd_data = cfg[0];
            A_CFG1:  rd_data = cfg[1];
            A_CFG2:  rd_data = cfg[2];
            A_MASK:  rd_data = mask_q;
            A_PEND:  rd_data = pend_q;
            A_FILT0: rd_data = filt[0];
            A_FILT1: rd_data = filt[1];
            A_FILT2: rd_data = filt[2];
            default: rd_data = '0;
        endcase
    end

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        assign cfg_flat[k*DW +: DW] = cfg[k];
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // R3: write-one-to-clear when nothing new arrives
    p_pend_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_wr && set_i == '0) |=> (pend_q == ($past(pend_q) & ~$past(wr_data))));

    // R10: pending bits only fall through a pending write
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLINES-1:0]  line_in,
    input  logic [AW-1:0]      addr,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    output logic [NDIRECT-1:0] irq_direct,
    output logic               irq_grp_lo,
    output logic               irq_grp_hi
);
    logic [NLINES-1:0]    lvl, hit, armed;
    logic [NCFG*DW-1:0]   cfg_flat;
    logic [DW-1:0]        mask, pend, set_word;
    logic                 unused_mask_bits;

    eint_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(line_in), .q(lvl)
    );

    eint_detect u_detect (
        .clk(clk), .rst(rst), .lvl(lvl), .cfg_flat(cfg_flat), .hit(hit)
    );

    assign armed    = hit & ~mask[NLINES-1:0];
    assign set_word = {{(DW-NLINES){1'b0}}, armed} & GROUPED_MASK;
    assign unused_mask_bits = ^{mask[DW-1:NLINES], mask[NDIRECT-1:0]};

    eint_regs u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .set_i(set_word), .rd_data(rd_data), .cfg_flat(cfg_flat),
        .mask_o(mask), .pend_o(pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_direct <= '0;
            irq_grp_lo <= 1'b0;
            irq_grp_hi <= 1'b0;
        end else begin
            irq_direct <= hit[NDIRECT-1:0];
            irq_grp_lo <= |armed[GRP_LO_MSB:NDIRECT];
            irq_grp_hi <= |armed[NLINES-1:GRP_HI_LSB];
        end
    end

    // R8: direct requests follow the line triggers one cycle later
    p_direct_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_direct == $past(hit[NDIRECT-1:0])));

    // R9: a shared request needs an unmasked trigger in its group
    p_grp_lo_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (((hit[GRP_LO_MSB:NDIRECT] & ~mask[GRP_LO_MSB:NDIRECT]) == '0)) |=> !irq_grp_lo);
    p_grp_hi_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (((hit[NLINES-1:GRP_HI_LSB] & ~mask[NLINES-1:GRP_HI_LSB]) == '0)) |=> !irq_grp_hi);

    // R10: an unmasked grouped trigger lands in the pending word
    p_set_pend_r10: assert property (@(posedge clk) disable iff (rst)
        (set_word != '0) |=> ((pend & $past(set_word)) == $past(set_word)));
endmodule

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
module eint_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] line_in = 24'hffffff;
    logic [3:0]  addr = 4'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_direct;
    logic        irq_grp_lo, irq_grp_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    eint_ctrl u_dut (
        .clk(clk), .rst(rst), .line_in(line_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_direct(irq_direct),
        .irq_grp_lo(irq_grp_lo), .irq_grp_hi(irq_grp_hi)
    );

    typedef struct packed {
        logic [4:0] line;
        logic [2:0] mode;
        logic       unmask;
        logic       start_lv;
        logic       end_lv;
        logic [3:0] exp_cnt;
        logic       exp_pend;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  3'b010, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0},  // R5 direct falling
        '{5'd2,  3'b100, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0},  // R6 R8 direct rising, mask ignored
        '{5'd5,  3'b011, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1},  // R5 R9 group lo
        '{5'd6,  3'b101, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1},  // R6 group lo
        '{5'd9,  3'b110, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1},  // R7 group hi falling
        '{5'd12, 3'b111, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1},  // R7 group hi rising
        '{5'd20, 3'b001, 1'b1, 1'b0, 1'b1, 4'd4, 1'b1},  // R4 high level
        '{5'd23, 3'b000, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1},  // R4 low level
        '{5'd7,  3'b100, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},  // R9 masked lo
        '{5'd15, 3'b010, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},  // R9 masked hi
        '{5'd10, 3'b100, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},  // R6 wrong direction
        '{5'd3,  3'b010, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0}   // R5 wrong direction
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic pick_out(input int ln);
        if (ln < 4)       return irq_direct[ln];
        else if (ln < 8)  return irq_grp_lo;
        else              return irq_grp_hi;
    endfunction

    task automatic run_vec(input vec_t v);
        int ln, cnt, first;
        logic [31:0] rv, exp_p;
        string tag;
        ln = int'(v.line);
        tag = $sformatf("R11 vec line %0d mode %b", ln, v.mode);
        wr(4'(ln / 8), 32'(v.mode) << ((ln % 8) * 4));
        wr(4'd3, v.unmask ? (32'h00fffff0 & ~(32'd1 << ln)) : 32'h00fffff0);
        @(negedge clk); line_in[ln] = v.start_lv;
        repeat (6) @(negedge clk);
        wr(4'd4, 32'hffffffff);
        line_in[ln] = v.end_lv;
        cnt = 0; first = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (pick_out(ln)) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
        chk({tag, " count (R4 R5 R6 R7 R8 R9)"}, 32'(cnt), 32'(v.exp_cnt));
        if (v.exp_cnt != 0) chk({tag, " first edge"}, 32'(first), 32'd3);
        rd(4'd4, rv);
        exp_p = v.exp_pend ? (32'd1 << ln) : 32'd0;
        chk({tag, " pending R10"}, rv, exp_p);
        line_in[ln] = 1'b1;
        repeat (4) @(negedge clk);
        wr(4'(ln / 8), 32'd0);
        wr(4'd3, 32'h00fffff0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {26'd0, irq_grp_hi, irq_grp_lo, irq_direct}, 32'd0);
        @(negedge clk); rst = 1'b0;
        rd(4'd3, rv); chk("R1 mask reset", rv, 32'h00fffff0);
        rd(4'd4, rv); chk("R1 pend reset", rv, 32'd0);
        for (int a = 0; a < 3; a++) begin
            rd(4'(a), rv); chk($sformatf("R1 trigger word %0d reset", a), rv, 32'd0);
        end
        for (int a = 5; a < 8; a++) begin
            rd(4'(a), rv); chk($sformatf("R1 R12 filter word %0d reset", a), rv, 32'd0);
        end
        repeat (4) @(negedge clk);

        // R2 mask write is trimmed
        wr(4'd3, 32'hffffffff);
        rd(4'd3, rv); chk("R2 mask trim ones", rv, 32'h00fffff0);
        wr(4'd3, 32'h0f00000f);
        rd(4'd3, rv); chk("R2 mask trim edge bits", rv, 32'd0);
        wr(4'd3, 32'h00fffff0);

        // R12 filter storage
        wr(4'd5, 32'hdeadbeef); wr(4'd6, 32'h12345678); wr(4'd7, 32'hffffffff);
        rd(4'd5, rv); chk("R12 filter 0", rv, 32'hdeadbeef);
        rd(4'd6, rv); chk("R12 filter 1", rv, 32'h12345678);
        rd(4'd7, rv); chk("R12 filter 2", rv, 32'hffffffff);
        chk("R12 no request from filter writes", {30'd0, irq_grp_hi, irq_grp_lo}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3 partial clears of several pending bits
        wr(4'd0, 32'h0002_0000);
        wr(4'd1, 32'h0000_0022);
        wr(4'd3, 32'h00fffce0);
        wr(4'd4, 32'hffffffff);
        @(negedge clk); line_in[4] = 1'b0; line_in[8] = 1'b0; line_in[9] = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd4, rv); chk("R10 three pending bits", rv, 32'h00000310);
        wr(4'd4, 32'h00000100);
        rd(4'd4, rv); chk("R3 clear bit 8 only", rv, 32'h00000210);
        wr(4'd4, 32'h00000000);
        rd(4'd4, rv); chk("R3 zero write keeps bits", rv, 32'h00000210);
        wr(4'd4, 32'hff00020f);
        rd(4'd4, rv); chk("R3 clear bit 9 only", rv, 32'h00000010);
        wr(4'd4, 32'h00000010);
        rd(4'd4, rv); chk("R3 clear last bit", rv, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule